// File: doc/BRIEF.md
# Two-Channel Bus Switch Control Target

This block is an I2C target that owns one 8-bit control byte for a two-way downstream bus switch. A fast system clock oversamples SCL and SDA. The block watches for START and STOP conditions and compares the incoming 7-bit address with a fixed five-bit prefix, which is set by a parameter, followed by two strap pins. It acknowledges a match. After that it either takes in data bytes or returns the control byte.

The two low bits of the control byte drive the channel-enable outputs. Two active-low interrupt inputs are synchronized and appear in the same byte as read-only status. SDA is handled as open drain: the block only ever pulls the line low through `sdaOe`, and the resolved bus level comes back in on `sdaIn`.

Top module: `chan_switch_ctl`

## Requirements
- R1: While reset is asserted and right after it, `chanEn` is 2'b00 and `sdaOe` is 0.
- R2: The address byte is sent MSB first as seven address bits and then a direction bit. The address bits are `ADDR_PREFIX` (default 5'b11100; 5'b11110 and 5'b01100 are the alternatives) followed by `strap[1]` and then `strap[0]`. On a match the block pulls SDA low for the ninth clock.
- R3: If the address does not match, the block never pulls SDA low, and the data bytes that follow leave `chanEn` unchanged until the next START.
- R4: A direction bit of 0 selects a write. In a write, each data byte is acknowledged by pulling SDA low. Bits 1:0 of the byte go to `chanEn[1:0]`, with bit 0 driving channel 0. `chanEn` changes only after the falling SCL edge that ends that acknowledge bit; it does not change when the eighth data bit arrives.
- R5: When several data bytes are written in one transaction, `chanEn` ends up holding the low bits of the last byte.
- R6: Written bits 7:2 have no effect. Bits 7:6 and 3:2 always read back as 0.
- R7: A direction bit of 1 selects a read. The block returns the control byte MSB first. Bit 5 is 1 when `intN[1]` is low, bit 4 is 1 when `intN[0]` is low, and bits 1:0 equal `chanEn`.
- R8: In a read, a master ACK makes the block send the same byte again. A master NACK makes it release SDA, and it leaves SDA released for any further clocks until STOP or START.
- R9: A repeated START in the middle of a transaction restarts the address phase, so a matching address that follows is acknowledged and served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | Resolved SDA line level |
| sdaOe | output | 1 | 1 pulls SDA low |
| strap | input | 2 | Address strap bits, strap[1] is the higher one |
| intN | input | 2 | Active-low channel interrupts |
| chanEn | output | 2 | Channel enables, bit 0 for channel 0 |

## Verification
The hardest cases to reach from the ports are those where the timing of the channel-enable update matters. One is the window between the eighth data bit and the end of the acknowledge clock; the other is a repeated START that follows a rejected address. To reach them, the bench drives the bus bit by bit through its own tasks. It checks `chanEn` with SCL held low after the eighth bit and again after the acknowledge falls. It also issues a repeated START straight after a NACKed address, without any STOP in between. For reads, the bench acknowledges several bytes in a row and then clocks one extra bit after the NACK, which shows that SDA stays released.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int NUM_CH    = 2;
  localparam int REG_W     = 8;
  localparam int BYTE_BITS = 8;
  localparam int INT_LSB   = 4;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef struct packed {
    logic shiftRx;
    logic loadTx;
    logic shiftTx;
    logic drvAck;
    logic drvRelease;
    logic commit;
  } swStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK, S_IGNORE
  } swState_t;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int          WIDTH     = 2,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stageQ [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[g] <= RESET_VAL;
        else       stageQ[g] <= d;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[g] <= RESET_VAL;
        else       stageQ[g] <= stageQ[g-1];
    end
  end

  assign q = stageQ[STAGES-1];
endmodule

// File: rtl/sw_datapath.sv
module sw_datapath import sw_pkg::*; #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b11100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strap,
  input  logic [NUM_CH-1:0] intN,
  input  swStrobe_t         strb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              sdaOe,
  output logic [NUM_CH-1:0] chanEn
);
  logic [1:0]        busS;
  logic              sclS, sdaS, sclD, sdaD;
  logic [NUM_CH-1:0] intS, intAct;
  logic [BYTE_BITS-1:0] rxQ;
  logic [REG_W-1:0]  txQ, regVal;
  logic [NUM_CH-1:0] chanQ;
  logic              oeQ;

  sw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) i_busSync (
    .clk(clk), .rstN(rstN), .d({sclIn, sdaIn}), .q(busS));

  sw_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .RESET_VAL('1)) i_intSync (
    .clk(clk), .rstN(rstN), .d(intN), .q(intS));

  assign sclS = busS[1];
  assign sdaS = busS[0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end

  assign sclRise  =  sclS & ~sclD;
  assign sclFall  = ~sclS &  sclD;
  assign startDet =  sclS &  sclD &  sdaD & ~sdaS;
  assign stopDet  =  sclS &  sclD & ~sdaD &  sdaS;
  assign sdaBit   =  sdaS;

  // receive shifter and address compare
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            rxQ <= '0;
    else if (strb.shiftRx) rxQ <= {rxQ[BYTE_BITS-2:0], sdaS};

  assign addrMatch = (rxQ[BYTE_BITS-1:1] == {ADDR_PREFIX, strap});
  assign rwBit     = rxQ[0];

  // control byte: live status plus stored enables, other bits zero
  assign intAct = ~intS;
  always_comb begin
    regVal = '0;
    regVal[NUM_CH-1:0]        = chanQ;
    regVal[INT_LSB +: NUM_CH] = intAct;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           chanQ <= '0;
    else if (strb.commit) chanQ <= rxQ[NUM_CH-1:0];

  // transmit shifter and open-drain drive
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      txQ <= '0;
      oeQ <= 1'b0;
    end else if (strb.loadTx) begin
      txQ <= regVal;
      oeQ <= ~regVal[REG_W-1];
    end else if (strb.shiftTx) begin
      txQ <= {txQ[REG_W-2:0], 1'b0};
      oeQ <= ~txQ[REG_W-2];
    end else if (strb.drvAck) begin
      oeQ <= 1'b1;
    end else if (strb.drvRelease) begin
      oeQ <= 1'b0;
    end

  assign sdaOe  = oeQ;
  assign chanEn = chanQ;

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(chanQ)); // R4
  AST_ONE_SDA_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadTx, strb.shiftTx, strb.drvAck, strb.drvRelease})); // R2
  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeQ) |-> !sclS); // R8
endmodule

// File: rtl/sw_control.sv
module sw_control import sw_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaBit,
  input  logic      addrMatch,
  input  logic      rwBit,
  output swStrobe_t strb
);
  swState_t         stateQ, stateNx;
  logic [CNT_W-1:0] cntQ, cntNx;
  logic             rwQ, rwNx, ackQ, ackNx;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
      rwQ    <= 1'b0;
      ackQ   <= 1'b0;
    end else begin
      stateQ <= stateNx;
      cntQ   <= cntNx;
      rwQ    <= rwNx;
      ackQ   <= ackNx;
    end

  always_comb begin
    stateNx = stateQ;
    cntNx   = cntQ;
    rwNx    = rwQ;
    ackNx   = ackQ;
    strb    = '0;
    if (startDet) begin
      stateNx         = S_ADDR;
      cntNx           = '0;
      strb.drvRelease = 1'b1;
    end else if (stopDet) begin
      stateNx         = S_IDLE;
      strb.drvRelease = 1'b1;
    end else begin
      case (stateQ)
        S_ADDR, S_WR: begin
          if (sclRise && cntQ < LAST_BIT) begin
            strb.shiftRx = 1'b1;
            cntNx        = cntQ + ONE;
          end else if (sclFall && cntQ == LAST_BIT) begin
            if (stateQ == S_WR) begin
              strb.drvAck = 1'b1;
              stateNx     = S_WR_ACK;
            end else if (addrMatch) begin
              strb.drvAck = 1'b1;
              rwNx        = rwBit;
              stateNx     = S_ADDR_ACK;
            end else begin
              stateNx = S_IGNORE;
            end
          end
        end
        S_ADDR_ACK: if (sclFall) begin
          cntNx = '0;
          if (rwQ) begin
            strb.loadTx = 1'b1;
            stateNx     = S_RD;
          end else begin
            strb.drvRelease = 1'b1;
            stateNx         = S_WR;
          end
        end
        S_WR_ACK: if (sclFall) begin
          strb.commit     = 1'b1;
          strb.drvRelease = 1'b1;
          cntNx           = '0;
          stateNx         = S_WR;
        end
        S_RD: begin
          if (sclRise) cntNx = cntQ + ONE;
          else if (sclFall) begin
            if (cntQ == LAST_BIT) begin
              strb.drvRelease = 1'b1;
              stateNx         = S_RD_ACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        S_RD_ACK: begin
          if (sclRise) ackNx = !sdaBit;
          else if (sclFall) begin
            cntNx = '0;
            if (ackQ) begin
              strb.loadTx = 1'b1;
              stateNx     = S_RD;
            end else begin
              stateNx = S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (stateQ == S_ADDR)); // R9
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (stateQ == S_IDLE)); // R8
  AST_IGNORED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IGNORE) |-> !(strb.drvAck || strb.loadTx || strb.commit)); // R3
endmodule

// File: rtl/chan_switch_ctl.sv
module chan_switch_ctl import sw_pkg::*; #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b11100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [1:0] strap,
  input  logic [1:0] intN,
  output logic [1:0] chanEn
);
  swStrobe_t strb;
  logic sclRise, sclFall, startDet, stopDet, sdaBit, addrMatch, rwBit;

  sw_datapath #(.SYNC_STAGES(SYNC_STAGES), .ADDR_PREFIX(ADDR_PREFIX)) i_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .intN(intN), .strb(strb), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rwBit(rwBit), .sdaOe(sdaOe), .chanEn(chanEn));

  sw_control i_control (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rwBit(rwBit), .strb(strb));
endmodule

// File: tb/test_chan_switch_ctl.sv
`timescale 1ns/1ps
module test_chan_switch_ctl;
  localparam int Q = 8;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [1:0] intN = 2'b11;
  logic sdaOe;
  logic [1:0] chanEn;
  logic sdaBus;
  int total = 0, bad = 0;

  assign sdaBus = sdaM & ~sdaOe;
  always #10 clk = ~clk;

  chan_switch_ctl i_chan_switch_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strap(strap), .intN(intN), .chanEn(chanEn));

  typedef struct packed {
    logic [6:0] addr;
    logic       rd;
    logic [7:0] data;
    logic [1:0] intN;
    logic       expAck;
    logic [1:0] expChan;
    logic [7:0] expRd;
  } vec_t;

  // strap = 2'b10, so the matching address is 7'h72
  localparam vec_t VEC [10] = '{
    '{7'h72, 1'b0, 8'h01, 2'b11, 1'b1, 2'b01, 8'h00},
    '{7'h72, 1'b0, 8'hFE, 2'b11, 1'b1, 2'b10, 8'h00}, // R6 high bits dropped
    '{7'h72, 1'b1, 8'h00, 2'b11, 1'b1, 2'b10, 8'h02},
    '{7'h72, 1'b1, 8'h00, 2'b10, 1'b1, 2'b10, 8'h12},
    '{7'h72, 1'b1, 8'h00, 2'b01, 1'b1, 2'b10, 8'h22},
    '{7'h73, 1'b0, 8'h03, 2'b11, 1'b0, 2'b10, 8'h00},
    '{7'h7A, 1'b0, 8'h00, 2'b11, 1'b0, 2'b10, 8'h00},
    '{7'h72, 1'b0, 8'h33, 2'b11, 1'b1, 2'b11, 8'h00},
    '{7'h72, 1'b1, 8'h00, 2'b00, 1'b1, 2'b11, 8'h33},
    '{7'h72, 1'b0, 8'h00, 2'b11, 1'b1, 2'b00, 8'h00}
  };

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_);
    total++;
    if (act !== exp_) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp_);
    end
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitN(Q);
    sclM = 1'b1; waitN(Q);
    sdaM = 1'b0; waitN(Q);
    sclM = 1'b0; waitN(Q);
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitN(Q);
    sclM = 1'b1; waitN(Q);
    sdaM = 1'b1; waitN(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    waitN(Q);
    sclM = 1'b1; waitN(Q);
    sclM = 1'b0; waitN(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitN(Q);
    sclM = 1'b1; waitN(H);
    b = sdaBus;  waitN(H);
    sclM = 1'b0; waitN(Q);
  endtask

  task automatic writeByte(input logic [7:0] d, output logic ackd);
    logic b;
    for (int k = 7; k >= 0; k--) sendBit(d[k]);
    recvBit(b);
    ackd = ~b;
  endtask

  task automatic readByte(output logic [7:0] d, input logic mAck);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      recvBit(b);
      d[k] = b;
    end
    sendBit(~mAck);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic b;
    logic [7:0] d;
    string tag;

    waitN(5);
    chk("R1 chanEn in reset", {6'd0, chanEn}, 8'h00);
    chk("R1 sdaOe in reset", {7'd0, sdaOe}, 8'h00);
    rstN = 1'b1;
    waitN(Q);
    chk("R1 chanEn after reset", {6'd0, chanEn}, 8'h00);
    chk("R1 sdaOe after reset", {7'd0, sdaOe}, 8'h00);

    // vector table
    for (int i = 0; i < 10; i++) begin
      intN = VEC[i].intN;
      waitN(Q);
      tag = VEC[i].expAck ? (VEC[i].rd ? "R7" : "R4") : "R3";
      busStart();
      writeByte({VEC[i].addr, VEC[i].rd}, ack);
      chk(VEC[i].expAck ? "R2 address ack" : "R3 address nack", {7'd0, ack}, {7'd0, VEC[i].expAck});
      if (VEC[i].rd) begin
        readByte(d, 1'b0);
        chk("R7 read value", d, VEC[i].expRd);
      end else begin
        writeByte(VEC[i].data, ack);
        chk({tag, " data ack"}, {7'd0, ack}, {7'd0, VEC[i].expAck});
      end
      busStop();
      waitN(Q);
      chk({tag, " chanEn"}, {6'd0, chanEn}, {6'd0, VEC[i].expChan});
    end

    // R4 timing and R5 last byte wins (chanEn is 00 here)
    intN = 2'b11;
    busStart();
    writeByte({7'h72, 1'b0}, ack);
    chk("R2 ack before burst", {7'd0, ack}, 8'h01);
    for (int k = 7; k >= 0; k--) sendBit(k < 2);
    chk("R4 no update before ack clock", {6'd0, chanEn}, 8'h00);
    recvBit(b);
    chk("R4 data ack", {7'd0, b}, 8'h00);
    chk("R4 update after ack clock", {6'd0, chanEn}, 8'h03);
    writeByte(8'h02, ack);
    chk("R5 second byte", {6'd0, chanEn}, 8'h02);
    writeByte(8'h01, ack);
    busStop();
    waitN(Q);
    chk("R5 last byte kept", {6'd0, chanEn}, 8'h01);

    // R6 reserved bits
    busStart();
    writeByte({7'h72, 1'b0}, ack);
    writeByte(8'hCE, ack);
    busStop();
    busStart();
    writeByte({7'h72, 1'b1}, ack);
    readByte(d, 1'b0);
    busStop();
    chk("R6 readback with reserved bits written", d, 8'h02);

    // R8 repeated read, then NACK release
    intN = 2'b10;
    waitN(Q);
    busStart();
    writeByte({7'h72, 1'b1}, ack);
    readByte(d, 1'b1);
    chk("R8 first byte", d, 8'h12);
    readByte(d, 1'b1);
    chk("R8 repeated byte", d, 8'h12);
    readByte(d, 1'b0);
    chk("R8 third byte", d, 8'h12);
    recvBit(b);
    chk("R8 released after nack", {7'd0, b}, 8'h01);
    chk("R8 sdaOe low after nack", {7'd0, sdaOe}, 8'h00);
    busStop();

    // R9 repeated start after a rejected address
    intN = 2'b11;
    busStart();
    writeByte({7'h73, 1'b0}, ack);
    chk("R3 wrong strap nack", {7'd0, ack}, 8'h00);
    busStart();
    writeByte({7'h72, 1'b0}, ack);
    chk("R9 ack after repeated start", {7'd0, ack}, 8'h01);
    writeByte(8'h01, ack);
    busStop();
    waitN(Q);
    chk("R9 write served", {6'd0, chanEn}, 8'h01);

    // R1 reset in mid-run
    rstN = 1'b0;
    waitN(2);
    chk("R1 chanEn cleared by reset", {6'd0, chanEn}, 8'h00);
    rstN = 1'b1;
    waitN(Q);

    summary();
    $finish;
  end
endmodule